// File: doc/BRIEF.md
# Cascaded AND/OR Reduction Chain with Shared Result Register

This block merges the output and flag registers of a cluster of branching-program machines into one shared value. The machines sit on a linear chain of routing stages; stage k takes the value arriving from stage k-1 and combines it bit by bit with machine k's register, using either AND or OR as set by that stage's configuration. The first stage starts from the identity constant of its own operation. A stage can also be bypassed, which puts the identity constant in place of its machine's value, so that machine takes no part in the result.

The chain's final value is captured into a common register when a load strobe is high. The register drives the block outputs, which feed back to machine 0 and are shared by every machine in the cluster. A value loaded at one edge is therefore visible to all machines one clock later. That is well inside one instruction of a machine that takes two clocks per instruction. The data lane is DATA_W bits wide. A narrower flag lane of FLAG_W bits is reduced by the same chain under the same per-stage configuration.

Top module: `cascade_route_chain`

## Requirements
- R1: While rst_n is low at a rising clock edge, both common registers (common_data, common_flag) become all zeros.
- R2: A stage whose op bit is 1 combines with bitwise AND. A stage whose op bit is 0 combines with bitwise OR. The op bit for stage k is stage_op[k].
- R3: The chain begins with the identity constant of stage 0's operation: all ones when stage_op[0]=1 (AND), all zeros when it is 0 (OR). With every stage set to OR, the result is the OR of all machine values. With every stage set to AND, it is the AND of all of them.
- R4: Stages are applied in machine order, 0 first and N_MACH-1 last. With mixed operations the result is f_{N-1}(...f_1(f_0(identity, m0), m1)..., m_{N-1}), so the result depends on where each operation sits.
- R5: When stage_bypass[k]=1, machine k's data and flag values have no effect on the result.
- R6: When every stage is bypassed, the result is the start constant: all ones if stage_op[0]=1, all zeros otherwise.
- R7: When load_en is high at a rising edge, the common registers take the chain result of that cycle's inputs. The new value appears on the outputs after that edge and is stable for the next clock.
- R8: When load_en is low at a rising edge, the common registers keep their value, whatever the machine inputs or configuration do.
- R9: The flag lane follows R2 to R8 with the same stage_op and stage_bypass bits, over FLAG_W bits taken from mach_flag. Machine k's slice of each flat input sits at bits [k*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_op | input | N_MACH | Per-stage operation: 1 = AND, 0 = OR |
| stage_bypass | input | N_MACH | Per-stage bypass: 1 = inject identity in place of the machine value |
| mach_data | input | N_MACH*DATA_W | Output registers of all machines, machine k at [k*DATA_W +: DATA_W] |
| mach_flag | input | N_MACH*FLAG_W | Flag registers of all machines, machine k at [k*FLAG_W +: FLAG_W] |
| load_en | input | 1 | Capture the chain result into the common registers |
| common_data | output | DATA_W | Common data register, fed back to machine 0 |
| common_flag | output | FLAG_W | Common flag register |

## Verification
The two functions that meet in one cycle are the capture of a new chain result into the common register and the use of the old one. Inputs and configuration change in the same cycle that load_en is raised, so the check after the edge must show the result of the new inputs and not a mix of old and new. The opposite case is also driven. load_en is held low while the machine values and configuration change, and each check compares against a model that holds the last loaded value. Bypass and operation ordering are combined in the same loads, so a fault in stage order or in identity injection shows up as a mismatch with the bench's reduction function.

// File: rtl/route_chain_pkg.sv
// Package: shared encodings for the AND/OR routing chain.
// Assumes the op bit is 1 for AND and 0 for OR.
package route_chain_pkg;

    localparam logic OP_AND = 1'b1;
    localparam logic OP_OR  = 1'b0;

    // Identity bit of an operation: 1 for AND, 0 for OR.
    function automatic logic ident_bit(input logic op);
        return (op == OP_AND);
    endfunction

endpackage

// File: rtl/route_box.sv
// One routing stage: combines the arriving chain value with the local
// machine value by AND or OR. With bypass set, the local value is replaced
// by the identity constant of the chosen operation. Purely combinational.
module route_box #(
    parameter int W = 16
) (
    input  logic [W-1:0] chain_in,
    input  logic [W-1:0] local_val,
    input  logic         op,
    input  logic         bypass,
    output logic [W-1:0] chain_out
);
    import route_chain_pkg::*;

    logic [W-1:0] contrib;

    // Pick the machine value or the identity constant.
    always_comb begin
        contrib = bypass ? {W{ident_bit(op)}} : local_val;
    end

    // Apply the configured bitwise operation.
    always_comb begin
        if (op == OP_AND) chain_out = chain_in & contrib;
        else              chain_out = chain_in | contrib;
    end

endmodule

// File: rtl/route_lane.sv
// A lane of N stages in machine order 0..N-1. Stage 0 starts from the
// identity constant of its own operation. Assumes flat input packing with
// machine k at [k*W +: W].
module route_lane #(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic [N-1:0]   ops,
    input  logic [N-1:0]   byp,
    input  logic [N*W-1:0] vals,
    output logic [W-1:0]   result
);
    import route_chain_pkg::*;

    logic [W-1:0] link [N+1];

    // Seed the chain with stage 0's identity.
    always_comb begin
        link[0] = {W{ident_bit(ops[0])}};
    end

    for (genvar k = 0; k < N; k++) begin : g_stage
        route_box #(.W(W)) i_box (
            .chain_in (link[k]),
            .local_val(vals[k*W +: W]),
            .op       (ops[k]),
            .bypass   (byp[k]),
            .chain_out(link[k+1])
        );
    end

    // Lane result is the value leaving the last stage.
    always_comb begin
        result = link[N];
    end

endmodule

// File: rtl/cascade_route_chain.sv
// Top: data and flag reduction lanes under one shared per-stage
// configuration, each feeding a common register that loads on load_en and
// holds otherwise. Synchronous active-low reset clears both registers.
module cascade_route_chain #(
    parameter int N_MACH = 8,
    parameter int DATA_W = 16,
    parameter int FLAG_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_MACH-1:0]        stage_op,
    input  logic [N_MACH-1:0]        stage_bypass,
    input  logic [N_MACH*DATA_W-1:0] mach_data,
    input  logic [N_MACH*FLAG_W-1:0] mach_flag,
    input  logic                     load_en,
    output logic [DATA_W-1:0]        common_data,
    output logic [FLAG_W-1:0]        common_flag
);

    logic [DATA_W-1:0] data_res;
    logic [FLAG_W-1:0] flag_res;

    route_lane #(.N(N_MACH), .W(DATA_W)) i_data_lane (
        .ops(stage_op), .byp(stage_bypass), .vals(mach_data), .result(data_res)
    );

    route_lane #(.N(N_MACH), .W(FLAG_W)) i_flag_lane (
        .ops(stage_op), .byp(stage_bypass), .vals(mach_flag), .result(flag_res)
    );

    // Common registers: clear on reset, capture on load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            common_data <= '0;
            common_flag <= '0;
        end else if (load_en) begin
            common_data <= data_res;
            common_flag <= flag_res;
        end
    end

endmodule

// Checker: properties of the common registers against the lane results.
module cascade_route_chain_chk #(
    parameter int N_MACH = 8,
    parameter int DATA_W = 16,
    parameter int FLAG_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_MACH-1:0]        stage_op,
    input logic [N_MACH-1:0]        stage_bypass,
    input logic [N_MACH*DATA_W-1:0] mach_data,
    input logic                     load_en,
    input logic [DATA_W-1:0]        data_res,
    input logic [FLAG_W-1:0]        flag_res,
    input logic [DATA_W-1:0]        common_data,
    input logic [FLAG_W-1:0]        common_flag
);
    logic [DATA_W-1:0] and_all;
    logic [DATA_W-1:0] or_all;

    // Independent reductions over all machine values.
    always_comb begin
        and_all = '1;
        or_all  = '0;
        for (int k = 0; k < N_MACH; k++) begin
            and_all = and_all & mach_data[k*DATA_W +: DATA_W];
            or_all  = or_all  | mach_data[k*DATA_W +: DATA_W];
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (common_data == '0 && common_flag == '0));

    a_r7_load_data: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> common_data == $past(data_res));

    a_r9_load_flag: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> common_flag == $past(flag_res));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(common_data) && $stable(common_flag)));

    a_r6_all_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && (&stage_bypass)) |=> common_data == {DATA_W{$past(stage_op[0])}});

    a_r3_all_and: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && (&stage_op) && !(|stage_bypass)) |=> common_data == $past(and_all));

    a_r3_all_or: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !(|stage_op) && !(|stage_bypass)) |=> common_data == $past(or_all));

endmodule

bind cascade_route_chain cascade_route_chain_chk #(
    .N_MACH(N_MACH), .DATA_W(DATA_W), .FLAG_W(FLAG_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .stage_op(stage_op), .stage_bypass(stage_bypass),
    .mach_data(mach_data), .load_en(load_en), .data_res(data_res),
    .flag_res(flag_res), .common_data(common_data), .common_flag(common_flag)
);

// File: tb/test_cascade_route_chain.sv
// Bench: directed corner cases plus seeded random loads and holds.
module test_cascade_route_chain;
    localparam int N  = 8;
    localparam int DW = 16;
    localparam int FW = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    stage_op;
    logic [N-1:0]    stage_bypass;
    logic [N*DW-1:0] mach_data;
    logic [N*FW-1:0] mach_flag;
    logic            load_en;
    logic [DW-1:0]   common_data;
    logic [FW-1:0]   common_flag;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] exp_d;
    logic [FW-1:0] exp_f;

    always #5 clk = ~clk;

    cascade_route_chain #(.N_MACH(N), .DATA_W(DW), .FLAG_W(FW)) i_cascade_route_chain (
        .clk(clk), .rst_n(rst_n), .stage_op(stage_op), .stage_bypass(stage_bypass),
        .mach_data(mach_data), .mach_flag(mach_flag), .load_en(load_en),
        .common_data(common_data), .common_flag(common_flag)
    );

    // Model of the data lane reduction (16 bits).
    function automatic logic [DW-1:0] model_d(input logic [N-1:0] op,
            input logic [N-1:0] by, input logic [N*DW-1:0] v);
        logic [DW-1:0] acc = op[0] ? '1 : '0;
        for (int k = 0; k < N; k++) begin
            if (!by[k]) acc = op[k] ? (acc & v[k*DW +: DW]) : (acc | v[k*DW +: DW]);
        end
        return acc;
    endfunction

    // Model of the flag lane reduction (4 bits).
    function automatic logic [FW-1:0] model_f(input logic [N-1:0] op,
            input logic [N-1:0] by, input logic [N*FW-1:0] v);
        logic [FW-1:0] acc = op[0] ? '1 : '0;
        for (int k = 0; k < N; k++) begin
            if (!by[k]) acc = op[k] ? (acc & v[k*FW +: FW]) : (acc | v[k*FW +: FW]);
        end
        return acc;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] ed, input logic [FW-1:0] ef);
        checks++;
        if (common_data !== ed || common_flag !== ef) begin
            failures++;
            $display("FAIL %s data=%h flag=%h expected data=%h flag=%h",
                     tag, common_data, common_flag, ed, ef);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(input logic ld, input logic [N-1:0] op, input logic [N-1:0] by,
                        input logic [N*DW-1:0] d, input logic [N*FW-1:0] f);
        stage_op = op; stage_bypass = by; mach_data = d; mach_flag = f; load_en = ld;
        if (ld) begin exp_d = model_d(op, by, d); exp_f = model_f(op, by, f); end
        @(negedge clk);
    endtask

    function automatic logic [N*DW-1:0] rnd_d();
        logic [N*DW-1:0] r;
        for (int k = 0; k < N; k++) r[k*DW +: DW] = DW'($urandom);
        return r;
    endfunction

    function automatic logic [N*FW-1:0] rnd_f();
        return (N*FW)'($urandom);
    endfunction

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N*DW-1:0] d;
        logic [N*FW-1:0] f;
        void'($urandom(32'd1234));
        rst_n = 1'b0; load_en = 1'b0; stage_op = '0; stage_bypass = '0;
        mach_data = '0; mach_flag = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", '0, '0);
        rst_n = 1'b1;

        // R3: all OR, all AND, with a load in the same cycle as new inputs
        d = rnd_d(); f = rnd_f();
        step(1, '0, '0, d, f);
        check("R3 all OR", exp_d, exp_f);
        step(1, '1, '0, d, f);
        check("R3 all AND", exp_d, exp_f);

        // R6: all bypassed, start constant follows stage 0 op
        step(1, 8'h01, '1, rnd_d(), rnd_f());
        check("R6 bypass AND start", 16'hFFFF, 4'hF);
        step(1, 8'hFE, '1, rnd_d(), rnd_f());
        check("R6 bypass OR start", 16'h0000, 4'h0);

        // R4/R2: order matters: m0 OR then m1 AND vs m0 AND then m1 OR
        d = '0; d[0 +: DW] = 16'h00F0; d[DW +: DW] = 16'h0F0F;
        f = '0; f[0 +: FW] = 4'h3; f[FW +: FW] = 4'h5;
        step(1, 8'b0000_0010, 8'b1111_1100, d, f);
        check("R4 OR-then-AND", 16'h0000, 4'h1);
        step(1, 8'b0000_0001, 8'b1111_1100, d, f);
        check("R4 AND-then-OR", 16'h0FFF, 4'h7);

        // R5: bypassed machine value changes, result unchanged
        d[2*DW +: DW] = 16'h1234;
        step(1, 8'h00, 8'b0000_0100, d, f);
        check("R5 bypass base", 16'h0FFF, 4'h7);
        d[2*DW +: DW] = 16'hF000; f[2*FW +: FW] = 4'h8;
        step(1, 8'h00, 8'b0000_0100, d, f);
        check("R5 bypass ignored", 16'h0FFF, 4'h7);

        // R8: hold while everything changes
        step(0, 8'hA5, 8'h3C, rnd_d(), rnd_f());
        check("R8 hold", 16'h0FFF, 4'h7);
        step(0, 8'h5A, 8'h00, rnd_d(), rnd_f());
        check("R8 hold again", 16'h0FFF, 4'h7);

        // R2/R7/R9: random loads and holds
        for (int i = 0; i < 300; i++) begin
            step(($urandom % 4) != 0, N'($urandom), N'($urandom % 3 == 0 ? $urandom : 0),
                 rnd_d(), rnd_f());
            check("R7 R9 random", exp_d, exp_f);
        end

        // R1: reset mid-run clears
        rst_n = 1'b0; load_en = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", '0, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule